// File: doc/BRIEF.md
# Parallel Display Write-Bus Sniffer

This block passively observes a parallel display write bus that has a 16-bit data bus, a register-select line and an active-low write strobe. It does not drive the bus. Each falling edge of the strobe marks one transaction. For each one the block records the select level and the data word into an internal buffer. Once the buffer holds a fixed number of records, capture stops. The block then streams every record, followed by a fixed marker word, through a byte-wide valid/ready port that feeds a UART transmitter.

The bus is asynchronous to the block clock. All bus lines pass through a two-flop synchronizer, and an edge detector runs on a third, delayed stage. The block clock must run at least twice as fast as the strobe toggle rate, which can reach about 4.7 MHz, and should run much faster than that. A single-cycle `arm` pulse clears the write pointer and opens a new capture window. `done` rises once the marker has gone out and stays high until the next arm.

Top module: `lcd_bus_sniffer`

## Requirements
- R1: After reset, `done` and `tx_valid` are low.
- R2: Exactly one record is taken per falling edge of `lcd_wr_n`. Holding the strobe low or high adds no record. The data is the bus state as it stood when the strobe fell.
- R3: A record is 32 bits. Bit 31 is the `lcd_rs` level, bits 30:16 are zero, and bits 15:0 are `lcd_db`.
- R4: A capture window takes exactly DEPTH records (default 64). Dumping then starts, and strobe edges during the dump do not change any record.
- R5: Records are sent in capture order. Each record is sent as four bytes, with bits 31:24 first and bits 7:0 last.
- R6: After the last record, the 32-bit marker 0x11223344 is sent in the same byte order (0x11, 0x22, 0x33, 0x44).
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change. The next byte appears only after a cycle in which both were high.
- R8: A pulse on `arm` outside a dump clears the write pointer and starts a new capture, including when a capture is already running. Strobe edges before any arm are ignored. A pulse on `arm` during a dump has no effect.
- R9: `done` rises after the last marker byte is accepted. While `done` is high, `tx_valid` is low, and `done` stays high until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that starts a capture window |
| lcd_wr_n | input | 1 | Observed write strobe, active low, asynchronous |
| lcd_rs | input | 1 | Observed register-select line, asynchronous |
| lcd_db | input | 16 | Observed data bus, asynchronous |
| tx_valid | output | 1 | A dump byte is offered |
| tx_data | output | 8 | Dump byte |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| done | output | 1 | Dump finished |

## Verification
The bench sends strobes before any arm, holds one strobe low for a long time, and sends extra strobes past the record limit while the dump is running. A design that captured outside its window, double-counted a long pulse or kept writing during the dump would send records that do not match the expected stream. The bench also re-arms in the middle of a capture and pulses arm during a dump. A pointer that failed to clear would misplace the second window's records, and a dump that honoured the late arm would break off early. In the second run, ready is stalled on a repeating pattern. A wrong byte order, a byte lost or repeated under backpressure, or a missing or misordered marker then shows up as a byte mismatch.

// File: rtl/lcdsnf_pkg.sv
package lcdsnf_pkg;
  localparam int REC_W  = 32;
  localparam int NBYTES = REC_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_DUMP = 2'd2,
    ST_FIN  = 2'd3
  } snf_state_e;

  function automatic logic [REC_W-1:0] pack_rec(input logic sel, input logic [15:0] dat);
    pack_rec = {sel, {(REC_W-17){1'b0}}, dat};
  endfunction
endpackage

// File: rtl/lcdsnf_sync.sv
module lcdsnf_sync #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n_i,
  input  logic          rs_i,
  input  logic [DW-1:0] db_i,
  output logic          fall_o,
  output logic          rs_o,
  output logic [DW-1:0] db_o
);
  localparam int W = DW + 2;
  localparam logic [W-1:0] IDLE_VAL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] st1_q, st2_q, st3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= IDLE_VAL;
      st2_q <= IDLE_VAL;
      st3_q <= IDLE_VAL;
    end else begin
      st1_q <= {wr_n_i, rs_i, db_i};
      st2_q <= st1_q;
      st3_q <= st2_q;
    end
  end

  // strobe high in the older stage, low in the newer one: a falling edge
  assign fall_o = st3_q[W-1] & ~st2_q[W-1];
  // the older stage holds the bus as it was just before the strobe fell
  assign rs_o   = st3_q[W-2];
  assign db_o   = st3_q[DW-1:0];
endmodule

// File: rtl/lcdsnf_store.sv
module lcdsnf_store #(
  parameter int DEPTH = 64,
  parameter int RW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [RW-1:0]            wdata,
  output logic                     last_o,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [RW-1:0]            rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [RW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d;
  logic          wptr_en;

  assign last_o = (wptr_q == AW'(DEPTH - 1));

  always_comb begin
    wptr_en = clr | we;
    wptr_d  = wptr_q;
    if (clr)     wptr_d = '0;
    else if (we) wptr_d = last_o ? '0 : wptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr_q <= '0;
    else if (wptr_en) wptr_q <= wptr_d;
  end

  always_ff @(posedge clk) begin
    if (we && !clr) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lcdsnf_dump.sv
module lcdsnf_dump #(
  parameter int          DEPTH  = 64,
  parameter logic [31:0] MARKER = 32'h1122_3344
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     active,
  input  logic                     ready,
  input  logic [31:0]              word_i,
  output logic [$clog2(DEPTH)-1:0] raddr,
  output logic [7:0]               byte_o,
  output logic                     end_o
);
  import lcdsnf_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]  widx_q, widx_d;
  logic [1:0]   bsel_q, bsel_d;
  logic         step, is_mark, cnt_en;
  logic [31:0]  cur;

  assign is_mark = (widx_q == (AW+1)'(DEPTH));
  assign raddr   = widx_q[AW-1:0];
  assign cur     = is_mark ? MARKER : word_i;
  assign byte_o  = cur[(NBYTES-1-int'(bsel_q))*8 +: 8];
  assign step    = active & ready;
  assign end_o   = step & is_mark & (bsel_q == 2'(NBYTES-1));

  always_comb begin
    cnt_en = start | step;
    widx_d = widx_q;
    bsel_d = bsel_q;
    if (start) begin
      widx_d = '0;
      bsel_d = '0;
    end else if (step) begin
      bsel_d = bsel_q + 1'b1;
      if (bsel_q == 2'(NBYTES-1) && !is_mark) widx_d = widx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      bsel_q <= '0;
    end else if (cnt_en) begin
      widx_q <= widx_d;
      bsel_q <= bsel_d;
    end
  end
endmodule

// File: rtl/lcd_bus_sniffer.sv
module lcd_bus_sniffer #(
  parameter int          DW     = 16,
  parameter int          DEPTH  = 64,
  parameter logic [31:0] MARKER = 32'h1122_3344
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          lcd_wr_n,
  input  logic          lcd_rs,
  input  logic [DW-1:0] lcd_db,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          done
);
  import lcdsnf_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic          fall, s_rs;
  logic [DW-1:0] s_db;

  lcdsnf_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_n_i(lcd_wr_n), .rs_i(lcd_rs), .db_i(lcd_db),
    .fall_o(fall), .rs_o(s_rs), .db_o(s_db)
  );

  snf_state_e st_q, st_d;
  logic       in_dump, cap_fire, clr, last, dump_end;
  logic [AW-1:0] raddr;
  logic [REC_W-1:0] rdata, rec;

  assign in_dump  = (st_q == ST_DUMP);
  assign clr      = arm & ~in_dump;
  assign cap_fire = (st_q == ST_CAPT) & fall & ~arm;
  assign rec      = pack_rec(s_rs, 16'(s_db));

  lcdsnf_store #(.DEPTH(DEPTH), .RW(REC_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(clr), .we(cap_fire), .wdata(rec), .last_o(last),
    .raddr(raddr), .rdata(rdata)
  );

  lcdsnf_dump #(.DEPTH(DEPTH), .MARKER(MARKER)) u_dump (
    .clk(clk), .rst_n(rst_sync_n),
    .start(cap_fire & last), .active(in_dump), .ready(tx_ready),
    .word_i(rdata), .raddr(raddr), .byte_o(tx_data), .end_o(dump_end)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (arm) st_d = ST_CAPT;
      ST_CAPT: if (!arm && cap_fire && last) st_d = ST_DUMP;
      ST_DUMP: if (dump_end) st_d = ST_FIN;
      ST_FIN:  if (arm) st_d = ST_CAPT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  assign tx_valid = in_dump;
  assign done     = (st_q == ST_FIN);
endmodule

// File: rtl/lcdsnf_chk.sv
module lcdsnf_chk #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       arm,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       done,
  input logic       cap_fire,
  input logic       in_dump
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)             cnt_q <= '0;
    else if (arm && !in_dump)    cnt_q <= '0;
    else if (cap_fire)           cnt_q <= cnt_q + 1'b1;
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_fire |-> (cnt_q < CW'(DEPTH)));

  a_r4_dump_after_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(tx_valid) |-> (cnt_q == CW'(DEPTH)));

  a_r7_hold_byte: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !tx_valid);

  a_r8_arm_restarts: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (arm && !in_dump) |=> (!done && !tx_valid));
endmodule

bind lcd_bus_sniffer lcdsnf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .arm(arm),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .done(done), .cap_fire(cap_fire), .in_dump(in_dump)
);

// File: tb/tb_lcd_bus_sniffer.sv
module tb_lcd_bus_sniffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic lcd_wr_n = 1'b1, lcd_rs = 1'b0;
  logic [15:0] lcd_db = '0;
  logic tx_valid, tx_ready = 1'b1, done;
  logic [7:0] tx_data;

  int checks = 0, failures = 0;
  int nbytes = 0;
  bit stall_mode = 0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_bus_sniffer dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .lcd_wr_n(lcd_wr_n),
    .lcd_rs(lcd_rs), .lcd_db(lcd_db), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int b = 3; b >= 0; b--) expq.push_back(w[b*8 +: 8]);
  endtask

  // one bus write; low_len cycles of strobe low; expected record queued if exp
  task automatic bus_write(input logic sel, input logic [15:0] d, input int low_len, input bit exp);
    @(negedge clk); lcd_rs = sel; lcd_db = d;
    repeat (2) @(negedge clk);
    lcd_wr_n = 1'b0;
    repeat (low_len) @(negedge clk);
    lcd_wr_n = 1'b1;
    repeat (3) @(negedge clk);
    if (exp) push_word({sel, 15'd0, d});   // R3 record layout
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // ready driver, changes just after posedge
  int rcyc = 0;
  initial forever begin
    @(posedge clk); #1;
    rcyc++;
    tx_ready = stall_mode ? ((rcyc % 3) != 0 && (rcyc % 7) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(tx_valid === 1'b1 && tx_data === prev_data, "R7 hold under stall", int'(tx_data), int'(prev_data));
      end
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        nbytes++;
        if (expq.size() == 0) chk(1'b0, "R4/R5 unexpected byte", int'(tx_data), -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(tx_data === e, "R5/R6 dump byte", int'(tx_data), int'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0, "R1 done after reset", int'(done), 0);
    chk(tx_valid === 1'b0, "R1 tx_valid after reset", int'(tx_valid), 0);

    // R8: strobes before any arm are ignored
    for (int i = 0; i < 3; i++) bus_write(1'b1, 16'hDEAD + 16'(i), 3, 0);
    repeat (5) @(negedge clk);
    chk(tx_valid === 1'b0 && done === 1'b0, "R8 idle strobes ignored", int'(tx_valid), 0);

    // run 1: ready always high
    pulse_arm();
    for (int i = 0; i < DEPTH; i++)
      bus_write(i[0], 16'(i * 16'h0407) ^ 16'hA5C3, (i == 5) ? 12 : 3, 1); // R2 long low at i=5
    push_word(32'h1122_3344);                 // R6 marker
    for (int i = 0; i < 2; i++) bus_write(1'b1, 16'hBEEF, 3, 0); // R4 past limit
    while (!done) @(negedge clk);
    chk(nbytes == DEPTH*4 + 4, "R4/R5 byte count run1", nbytes, DEPTH*4 + 4);
    chk(expq.size() == 0, "R6 marker consumed run1", expq.size(), 0);
    chk(tx_valid === 1'b0, "R9 valid low when done", int'(tx_valid), 0);
    repeat (6) @(negedge clk);
    chk(done === 1'b1, "R9 done stays high", int'(done), 1);

    // run 2: re-arm mid capture, stalls, arm during dump ignored
    nbytes = 0;
    stall_mode = 1;
    pulse_arm();
    @(negedge clk);
    chk(done === 1'b0, "R8 arm clears done", int'(done), 0);
    for (int i = 0; i < 10; i++) bus_write(1'b0, 16'h1111 * 16'(i), 3, 0);
    pulse_arm();                              // R8 restart clears pointer
    for (int i = 0; i < DEPTH; i++)
      bus_write(~i[1], 16'(16'hFFFF - 16'(i * 257)), 3, 1);
    push_word(32'h1122_3344);
    for (int i = 0; i < 4; i++) bus_write(1'b0, 16'h0F0F, 3, 0); // R4 ignored in dump
    pulse_arm();                              // R8 ignored during dump
    chk(tx_valid === 1'b1, "R8 arm ignored in dump", int'(tx_valid), 1);
    while (!done) @(negedge clk);
    chk(nbytes == DEPTH*4 + 4, "R4/R5 byte count run2", nbytes, DEPTH*4 + 4);
    chk(expq.size() == 0, "R6 marker consumed run2", expq.size(), 0);
    chk(tx_valid === 1'b0, "R9 valid low run2", int'(tx_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule